// File: doc/BRIEF.md
# Battery Level and Shutdown Monitor

This block watches periodic battery-voltage readings from a 10-bit successive-approximation monitoring converter. From them it derives a five-step charge indicator (bars 0 to 4), a low-voltage warning and a forced-shutdown request. Each threshold is a parameter in millivolts. The block turns each one into a converter code through a parameterised scale, given in microvolts per code. The default scale is 5000 µV per code. Bar changes use hysteresis: a level can fall on a single sample, but it rises only after a run of consecutive higher samples. While the indicator sits at its lowest bar, a blanking output toggles so that the display can flash that bar.

The warning threshold depends on whether a call is in progress. The call flag is taken together with each sample. The shutdown threshold lies below both warning levels. A shutdown request is raised only after several consecutive low readings, so that short dips during transmit bursts do not trip it. Once raised, the request holds until reset. Nothing changes except on a clock edge where a sample is valid.

Top module: `batt_level_mon`

## Requirements
- R1: With the default scale, a sample code of 784 or more classifies as bar 4, 758..783 as bar 3, 744..757 as bar 2, 732..743 as bar 1, and below 732 as bar 0.
- R2: A valid sample whose class is below the shown bar sets the shown bar to that class on the edge that takes the sample.
- R3: The shown bar rises only on the third consecutive valid sample (RISE_N = 3) whose class is above it. It then takes that sample's class. A sample whose class is equal or lower restarts the run.
- R4: After reset the shown bar is 4, and the warning, shutdown and blanking outputs are 0.
- R5: With the call flag low, each valid sample sets the warning to 1 if its code is below 720 and to 0 otherwise.
- R6: With the call flag high, each valid sample sets the warning to 1 if its code is below 700 and to 0 otherwise. The call flag counts only on the sample's edge.
- R7: The shutdown request rises on the fourth consecutive valid sample (SHUT_N = 4) with a code below 670. A sample at or above 670 restarts the count.
- R8: Once raised, the shutdown request stays high until reset, whatever samples follow.
- R9: While the shown bar is 0, the blanking output toggles on every second valid sample (BLINK_N = 2), counted from entry to bar 0 with the output starting at 0. Whenever the shown bar is above 0, the blanking output is 0 and its count restarts.
- R10: All outputs change only on an edge where the sample-valid input is high, and they hold between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per conversion |
| smp_code | input | 10 | Battery-voltage code from the converter |
| in_call | input | 1 | High while a call is in progress, taken with each sample |
| bar_level | output | 3 | Shown charge level, 0 to 4 |
| bar_dark | output | 1 | Blanking phase for the lowest bar |
| low_warn | output | 1 | Low-voltage warning |
| shut_req | output | 1 | Latched forced-shutdown request |

## Verification
The bench probes each bar edge at its exact code and one code below it. A comparator that uses the wrong operator shows up there as an off-by-one bar. It breaks rising runs with a lower sample one step short of RISE_N, which catches a counter that is not cleared and would let the bar climb early. It also interrupts a run of low samples with a single 670-or-above reading, so a design that forgets to clear the count would request shutdown early. The bench toggles the call flag around codes lying between the two warning levels. It inserts idle cycles between samples to expose any state that moves without a strobe, and it confirms that the shutdown request survives recovered readings.

// File: rtl/batt_mon_pkg.sv
// Package: shared types and the millivolt-to-code conversion used by the
// battery monitor. Assumes an unsigned linear converter transfer function.
package batt_mon_pkg;

    typedef logic [2:0] bar_t;

    localparam int unsigned NUM_EDGES = 4;

    // Converts a threshold in millivolts to a converter code (truncating).
    function automatic int unsigned mv_to_code(input int unsigned mv,
                                               input int unsigned lsb_uv);
        return (mv * 1000) / lsb_uv;
    endfunction

endpackage

// File: rtl/batt_bar_classify.sv
// Module: combinational classifier from sample code to raw bar class.
// Assumes the edge codes rise strictly from EDGE1 to EDGE4.
module batt_bar_classify
    import batt_mon_pkg::*;
#(
    parameter int unsigned ADC_W = 10,
    parameter logic [ADC_W-1:0] EDGE1 = 10'd732,
    parameter logic [ADC_W-1:0] EDGE2 = 10'd744,
    parameter logic [ADC_W-1:0] EDGE3 = 10'd758,
    parameter logic [ADC_W-1:0] EDGE4 = 10'd784
) (
    input  logic [ADC_W-1:0] code,
    output bar_t             raw_bar
);

    localparam logic [NUM_EDGES-1:0][ADC_W-1:0] EDGES = {EDGE4, EDGE3, EDGE2, EDGE1};

    logic [NUM_EDGES-1:0] above;

    for (genvar gi = 0; gi < NUM_EDGES; gi++) begin : g_cmp
        assign above[gi] = (code >= EDGES[gi]);
    end

    // Counts how many edges the code reaches or passes.
    always_comb begin
        raw_bar = '0;
        for (int i = 0; i < NUM_EDGES; i++) begin
            if (above[i]) raw_bar = raw_bar + bar_t'(1);
        end
    end

endmodule

// File: rtl/batt_bar_hyst.sv
// Module: shown-bar register with hysteresis. A lower class is taken at
// once; a higher class only after RISE_N consecutive higher samples.
// Assumes RISE_N >= 1. Resets to the full bar.
module batt_bar_hyst
    import batt_mon_pkg::*;
#(
    parameter int unsigned RISE_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  bar_t raw_bar,
    output bar_t lvl_q,
    output bar_t lvl_nxt
);

    localparam int unsigned CW = $clog2(RISE_N + 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_N - 1);

    logic [CW-1:0] cnt_q, cnt_nxt;

    // Next shown bar and rising-run count.
    always_comb begin
        lvl_nxt = lvl_q;
        cnt_nxt = cnt_q;
        if (vld) begin
            if (raw_bar < lvl_q) begin
                lvl_nxt = raw_bar;
                cnt_nxt = '0;
            end else if (raw_bar > lvl_q) begin
                if (cnt_q == RISE_LAST) begin
                    lvl_nxt = raw_bar;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q + CW'(1);
                end
            end else begin
                cnt_nxt = '0;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= bar_t'(4);
            cnt_q <= '0;
        end else begin
            lvl_q <= lvl_nxt;
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/batt_blink.sv
// Module: blanking phase for the lowest bar. Toggles every BLINK_N valid
// samples while the next shown bar is 0, otherwise held at 0.
// Assumes BLINK_N >= 1.
module batt_blink
    import batt_mon_pkg::*;
#(
    parameter int unsigned BLINK_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  bar_t lvl_nxt,
    output logic dark
);

    localparam int unsigned CW = $clog2(BLINK_N + 1);
    localparam logic [CW-1:0] BLINK_LAST = CW'(BLINK_N - 1);

    logic [CW-1:0] cnt_q;

    // Sample counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dark  <= 1'b0;
        end else if (vld) begin
            if (lvl_nxt != bar_t'(0)) begin
                cnt_q <= '0;
                dark  <= 1'b0;
            end else if (cnt_q == BLINK_LAST) begin
                cnt_q <= '0;
                dark  <= ~dark;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/batt_shut_filter.sv
// Module: forced-shutdown filter. Raises a sticky request after SHUT_N
// consecutive valid samples flagged below the threshold.
// Assumes SHUT_N >= 1.
module batt_shut_filter #(
    parameter int unsigned SHUT_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic below,
    output logic shut
);

    localparam int unsigned CW = $clog2(SHUT_N + 1);
    localparam logic [CW-1:0] SHUT_LAST = CW'(SHUT_N - 1);

    logic [CW-1:0] cnt_q;

    // Run counter and latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            shut  <= 1'b0;
        end else if (vld && !shut) begin
            if (!below) begin
                cnt_q <= '0;
            end else if (cnt_q == SHUT_LAST) begin
                shut <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/batt_level_mon.sv
// Module: top of the battery level and shutdown monitor. Converts the
// millivolt thresholds to codes, classifies each sample, and drives the
// shown bar, blanking phase, low warning and shutdown request.
// Assumes one-cycle sample strobes and a linear converter scale.
module batt_level_mon
    import batt_mon_pkg::*;
#(
    parameter int unsigned ADC_W    = 10,
    parameter int unsigned LSB_UV   = 5000,
    parameter int unsigned BAR1_MV  = 3660,
    parameter int unsigned BAR2_MV  = 3720,
    parameter int unsigned BAR3_MV  = 3790,
    parameter int unsigned BAR4_MV  = 3920,
    parameter int unsigned IDLE_MV  = 3600,
    parameter int unsigned CALL_MV  = 3500,
    parameter int unsigned SHUT_MV  = 3350,
    parameter int unsigned RISE_N   = 3,
    parameter int unsigned SHUT_N   = 4,
    parameter int unsigned BLINK_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [ADC_W-1:0] smp_code,
    input  logic             in_call,
    output logic [2:0]       bar_level,
    output logic             bar_dark,
    output logic             low_warn,
    output logic             shut_req
);

    localparam logic [ADC_W-1:0] EDGE1_C = ADC_W'(mv_to_code(BAR1_MV, LSB_UV));
    localparam logic [ADC_W-1:0] EDGE2_C = ADC_W'(mv_to_code(BAR2_MV, LSB_UV));
    localparam logic [ADC_W-1:0] EDGE3_C = ADC_W'(mv_to_code(BAR3_MV, LSB_UV));
    localparam logic [ADC_W-1:0] EDGE4_C = ADC_W'(mv_to_code(BAR4_MV, LSB_UV));
    localparam logic [ADC_W-1:0] IDLE_C  = ADC_W'(mv_to_code(IDLE_MV, LSB_UV));
    localparam logic [ADC_W-1:0] CALL_C  = ADC_W'(mv_to_code(CALL_MV, LSB_UV));
    localparam logic [ADC_W-1:0] SHUT_C  = ADC_W'(mv_to_code(SHUT_MV, LSB_UV));

    bar_t raw_bar;
    bar_t lvl_q;
    bar_t lvl_nxt;
    logic below_shut;

    batt_bar_classify #(
        .ADC_W (ADC_W),
        .EDGE1 (EDGE1_C),
        .EDGE2 (EDGE2_C),
        .EDGE3 (EDGE3_C),
        .EDGE4 (EDGE4_C)
    ) u_classify (
        .code    (smp_code),
        .raw_bar (raw_bar)
    );

    batt_bar_hyst #(
        .RISE_N (RISE_N)
    ) u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (smp_vld),
        .raw_bar (raw_bar),
        .lvl_q   (lvl_q),
        .lvl_nxt (lvl_nxt)
    );

    batt_blink #(
        .BLINK_N (BLINK_N)
    ) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (smp_vld),
        .lvl_nxt (lvl_nxt),
        .dark    (bar_dark)
    );

    assign below_shut = (smp_code < SHUT_C);

    batt_shut_filter #(
        .SHUT_N (SHUT_N)
    ) u_shut (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (smp_vld),
        .below (below_shut),
        .shut  (shut_req)
    );

    // Warning register: threshold chosen by the call flag of the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_warn <= 1'b0;
        end else if (smp_vld) begin
            low_warn <= in_call ? (smp_code < CALL_C) : (smp_code < IDLE_C);
        end
    end

    assign bar_level = lvl_q;

endmodule

// File: rtl/batt_level_mon_chk.sv
// Module: assertion checker for the battery monitor, bound to the top.
// Assumes it sees the top's ports and its raw class signal.
module batt_level_mon_chk #(
    parameter int unsigned ADC_W = 10,
    parameter logic [ADC_W-1:0] CALL_CODE = 10'd700
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic [ADC_W-1:0] smp_code,
    input logic             in_call,
    input logic [2:0]       raw_bar,
    input logic [2:0]       bar_level,
    input logic             bar_dark,
    input logic             low_warn,
    input logic             shut_req
);

    // R1: the shown bar never leaves 0..4
    a_r1_bar_range: assert property (@(posedge clk) disable iff (!rst_n)
        bar_level <= 3'd4);

    // R2: a lower class is taken on the sample edge
    a_r2_drop_now: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && (raw_bar < bar_level) |=> bar_level == $past(raw_bar));

    // R3: a sample not above the shown bar never raises it
    a_r3_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && (raw_bar <= bar_level) |=> bar_level <= $past(bar_level));

    // R6: during a call the lower warning level applies
    a_r6_call_level: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && in_call |=> low_warn == ($past(smp_code) < CALL_CODE));

    // R8: shutdown request is sticky
    a_r8_shut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        shut_req |=> shut_req);

    // R9: blanking only at bar 0
    a_r9_dark_bar0: assert property (@(posedge clk) disable iff (!rst_n)
        bar_dark |-> bar_level == 3'd0);

    // R10: nothing moves without a sample
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(bar_level) && $stable(low_warn) && $stable(bar_dark));

endmodule

bind batt_level_mon batt_level_mon_chk #(
    .ADC_W     (ADC_W),
    .CALL_CODE (CALL_C)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_code  (smp_code),
    .in_call   (in_call),
    .raw_bar   (raw_bar),
    .bar_level (bar_level),
    .bar_dark  (bar_dark),
    .low_warn  (low_warn),
    .shut_req  (shut_req)
);

// File: tb/test_batt_level_mon.sv
// Bench: behavioural reference model compared with the outputs every clock.
module test_batt_level_mon;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [9:0] smp_code = '0;
    logic       in_call = 1'b0;
    logic [2:0] bar_level;
    logic       bar_dark;
    logic       low_warn;
    logic       shut_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_lvl = 4, m_rc = 0, m_bc = 0, m_sc = 0;
    bit m_dark = 0, m_warn = 0, m_shut = 0;

    always #2 clk = ~clk;

    batt_level_mon i_batt_level_mon (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
        .in_call(in_call), .bar_level(bar_level), .bar_dark(bar_dark),
        .low_warn(low_warn), .shut_req(shut_req)
    );

    function automatic int cls(input int c);
        if (c >= 784) return 4;
        if (c >= 758) return 3;
        if (c >= 744) return 2;
        if (c >= 732) return 1;
        return 0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        chk(tag, "bar_level", int'(bar_level), m_lvl);
        chk(tag, "bar_dark", int'(bar_dark), int'(m_dark));
        chk(tag, "low_warn", int'(low_warn), int'(m_warn));
        chk(tag, "shut_req", int'(shut_req), int'(m_shut));
    endtask

    task automatic model_step(input int c, input bit call);
        int r;
        r = cls(c);
        if (r < m_lvl) begin m_lvl = r; m_rc = 0; end
        else if (r > m_lvl) begin
            m_rc++;
            if (m_rc == 3) begin m_lvl = r; m_rc = 0; end
        end else m_rc = 0;
        if (m_lvl != 0) begin m_bc = 0; m_dark = 0; end
        else begin
            m_bc++;
            if (m_bc == 2) begin m_bc = 0; m_dark = ~m_dark; end
        end
        m_warn = call ? (c < 700) : (c < 720);
        if (!m_shut) begin
            if (c < 670) begin m_sc++; if (m_sc == 4) m_shut = 1; end
            else m_sc = 0;
        end
    endtask

    // One sample: drive at negedge, model at posedge, compare at next negedge.
    task automatic smp(input int c, input bit call, input string tag);
        smp_vld  = 1'b1;
        smp_code = 10'(c);
        in_call  = call;
        @(posedge clk);
        model_step(c, call);
        @(negedge clk);
        smp_vld = 1'b0;
        in_call = ~call;
        cmp_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            smp_code = 10'(i * 97);
            @(negedge clk);
            cmp_all(tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R4");
        // R2 stepwise drops from full
        smp(800, 0, "R1");
        smp(760, 0, "R2");
        smp(745, 0, "R2");
        smp(735, 0, "R2");
        smp(715, 0, "R5");
        // R9 blanking at bar 0
        for (int i = 0; i < 5; i++) smp(710, 0, "R9");
        // R3 broken run then full run
        smp(790, 0, "R3");
        smp(790, 0, "R3");
        smp(700, 0, "R3");
        smp(790, 0, "R3");
        smp(790, 0, "R3");
        smp(795, 0, "R3");
        smp(790, 0, "R9");
        // R6 call threshold
        smp(710, 1, "R6");
        smp(710, 0, "R5");
        smp(699, 1, "R6");
        smp(700, 1, "R6");
        smp(720, 0, "R5");
        smp(719, 0, "R5");
        idle(4, "R10");
        // R1 edge codes
        smp(784, 0, "R1"); smp(784, 0, "R1"); smp(784, 0, "R1");
        smp(783, 0, "R1");
        smp(758, 0, "R1");
        smp(757, 0, "R1");
        smp(744, 0, "R1");
        smp(743, 0, "R1");
        smp(732, 0, "R1");
        smp(731, 0, "R1");
        // R7 interrupted low run, then full
        smp(660, 0, "R7"); smp(660, 0, "R7"); smp(669, 0, "R7");
        smp(670, 0, "R7");
        smp(660, 1, "R7"); smp(660, 1, "R7"); smp(660, 1, "R7");
        smp(660, 1, "R7");
        idle(3, "R10");
        // R8 sticky after recovery
        for (int i = 0; i < 4; i++) smp(800, 0, "R8");
        smp(600, 0, "R8");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule